// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter

This block turns a stream of 32-bit audio sample words into a serial bit stream aligned to an external bit clock and word-select pair. Two framings are supported. In the I2S framing, word select low marks the left channel and the MSB comes one bit period after the word-select edge. In the left-justified framing, word select high marks the left channel and the MSB comes with the edge. The bit clock and word select always arrive as inputs. They come from the far end in slave operation, or from a separate clock generator in master operation. Both are oversampled on the system clock through a synchronizer of `SYNC_STAGES` flops.

A static configuration picks the framing, one of eight word-length codes, a 24- or 32-bit slot for the 18/20/24-bit lengths, mono duplication, and the underrun policy. The block copies the configuration only while `enable` is low, so changes made while it runs have no effect. The `slot_bits` output gives the slot length that follows from the captured configuration, for the clock generator to use when it sizes the word-select period. Samples come over a valid/ready port. The block raises `s_ready` for exactly one system clock at the moment a slot needs data, and a word is taken only when `s_valid` is high in that same cycle. The source cannot stall the serial line. If `s_valid` is low in the ready cycle, that slot is an underrun.

Top module: `aud_ser_tx`

## Requirements
- R1: While `enable` is low (and after reset) `sdo` and `s_ready` are 0, and the configuration inputs are copied each cycle into the captured configuration.
- R2: In left-justified framing (format code 1), ws=1 is the left slot and the sample MSB is sent in the bit period that begins on the word-select edge.
- R3: In I2S framing (format codes 0, 2 and 3), ws=0 is the left slot and the MSB is sent one bit period after the edge. The bit period that starts on the edge carries the previous slot's bit at position slot_bits-1.
- R4: Word-length codes are 0=32, 1=24, 2=20, 3=18, 4=16, 6=8 bits. A sample sits in the low bits of its word and is sent MSB first. Upper word bits are ignored, and slot positions past the data length are sent as 0.
- R5: Code 5 packs two 16-bit samples into one word, with left in bits 15:0 and right in bits 31:16. Code 7 packs two 8-bit samples, with left in bits 7:0 and right in bits 15:8. One word serves one frame.
- R6: `slot_bits` is 32 for code 0; 32 or 24 for codes 1–3 when the slot select is 0 or 1; 16 for codes 4–5; and 8 for codes 6–7.
- R7: With mono set, one word per frame is taken and its left sample is sent in both slots.
- R8: On underrun a slot sends zero, or, with repeat set, the last sample taken for that channel.
- R9: `s_ready` is high for one system clock at each slot load that needs a word: every slot in plain stereo, and only the left slot for the packed codes and for mono.
- R10: After enable, nothing is taken and `sdo` stays 0 until the first left slot starts, so the first word taken is always a left sample.
- R11: Configuration input changes while `enable` is high change neither the serial output nor `slot_bits`.
- R12: `sdo` changes only in response to a detected falling edge of the bit clock, and it holds for the rest of that bit period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control; configuration is captured while low |
| cfg_format | input | 2 | Framing: 1 left-justified, others I2S |
| cfg_wlen | input | 3 | Word-length code |
| cfg_slot24 | input | 1 | 24-bit slot for 18/20/24-bit lengths |
| cfg_mono | input | 1 | Duplicate left sample into right slot |
| cfg_repeat | input | 1 | Repeat last sample on underrun instead of zero |
| s_valid | input | 1 | Sample word valid |
| s_ready | output | 1 | One-cycle request for a sample word |
| s_data | input | 32 | Sample word |
| bck_in | input | 1 | Bit clock |
| ws_in | input | 1 | Word select |
| sdo | output | 1 | Serial data, updated after bit-clock falling edges |
| slot_bits | output | 6 | Slot length from captured configuration |

## Verification
The bench builds the block with `SYNC_STAGES` at its default of 2 and a bit period of eight system clocks. With that spacing, the synchronizer delay plus the register stage settles before the bench samples at each bit-clock rise. The timing margin and the bit-level framing of both formats can therefore be checked exactly. The bench drives a short right-level lead-in before the first frame, so start alignment is exercised in every run. The bench also uses slot lengths of 8, 16, 24 and 32, so the I2S carry of the previous slot's last bit is observed at each shift-register depth.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;

  localparam int WORD_W = 32;
  localparam int SLOT_W = 6;

  typedef enum logic [2:0] {
    WL_32  = 3'd0,
    WL_24  = 3'd1,
    WL_20  = 3'd2,
    WL_18  = 3'd3,
    WL_16  = 3'd4,
    WL_16P = 3'd5,
    WL_8   = 3'd6,
    WL_8P  = 3'd7
  } wlen_e;

  typedef struct packed {
    logic  lj;
    wlen_e wlen;
    logic  slot24;
    logic  mono;
    logic  rep;
  } cfg_t;

  // Sample moved to the top of the word, zero filled below its length.
  function automatic logic [WORD_W-1:0] align_sample(input logic [WORD_W-1:0] w,
                                                     input wlen_e c,
                                                     input logic hi);
    logic [WORD_W-1:0] r;
    case (c)
      WL_32:   r = w;
      WL_24:   r = {w[23:0], 8'h00};
      WL_20:   r = {w[19:0], 12'h000};
      WL_18:   r = {w[17:0], 14'h0000};
      WL_16:   r = {w[15:0], 16'h0000};
      WL_16P:  r = hi ? {w[31:16], 16'h0000} : {w[15:0], 16'h0000};
      WL_8:    r = {w[7:0], 24'h000000};
      default: r = hi ? {w[15:8], 24'h000000} : {w[7:0], 24'h000000};
    endcase
    return r;
  endfunction

  function automatic logic [SLOT_W-1:0] slot_len(input wlen_e c, input logic s24);
    logic [SLOT_W-1:0] n;
    case (c)
      WL_32:                n = 6'd32;
      WL_24, WL_20, WL_18:  n = s24 ? 6'd24 : 6'd32;
      WL_16, WL_16P:        n = 6'd16;
      default:              n = 6'd8;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/aud_ser_edge.sv
module aud_ser_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bck_in,
  input  logic ws_in,
  output logic fall,
  output logic ws_now,
  output logic slot_edge,
  output logic edge_prev
);
  logic bck_s;
  logic bck_q;
  logic ws_fall_q;
  logic primed;

  generate
    if (SYNC_STAGES > 0) begin : g_sync
      logic [SYNC_STAGES-1:0] bck_sr;
      logic [SYNC_STAGES-1:0] ws_sr;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bck_sr <= '1;
          ws_sr  <= '0;
        end else begin
          bck_sr[0] <= bck_in;
          ws_sr[0]  <= ws_in;
          for (int i = 1; i < SYNC_STAGES; i++) begin
            bck_sr[i] <= bck_sr[i-1];
            ws_sr[i]  <= ws_sr[i-1];
          end
        end
      end
      assign bck_s  = bck_sr[SYNC_STAGES-1];
      assign ws_now = ws_sr[SYNC_STAGES-1];
    end else begin : g_direct
      assign bck_s  = bck_in;
      assign ws_now = ws_in;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bck_q <= 1'b1;
    else        bck_q <= bck_s;
  end

  assign fall      = en && bck_q && !bck_s;
  assign slot_edge = primed && (ws_now != ws_fall_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed    <= 1'b0;
      ws_fall_q <= 1'b0;
      edge_prev <= 1'b0;
    end else if (!en) begin
      primed    <= 1'b0;
      edge_prev <= 1'b0;
    end else if (fall) begin
      primed    <= 1'b1;
      ws_fall_q <= ws_now;
      edge_prev <= slot_edge;
    end
  end
endmodule

// File: rtl/aud_ser_src.sv
module aud_ser_src
  import aud_ser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  cfg_t              cfg,
  input  logic              load,
  input  logic              left,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_data,
  output logic [WORD_W-1:0] smp
);
  logic              started;
  logic              hold_ok;
  logic [WORD_W-1:0] hold_r;
  logic [WORD_W-1:0] last_l;
  logic [WORD_W-1:0] last_r;
  logic              per_frame;
  logic              take;
  logic [WORD_W-1:0] al_lo;
  logic [WORD_W-1:0] al_hi;
  logic              fresh_r;

  assign per_frame = (cfg.wlen == WL_16P) || (cfg.wlen == WL_8P) || cfg.mono;
  assign s_ready   = load && (left || (started && !per_frame));
  assign take      = s_ready && s_valid;
  assign al_lo     = align_sample(s_data, cfg.wlen, 1'b0);
  assign al_hi     = align_sample(s_data, cfg.wlen, 1'b1);
  assign fresh_r   = per_frame ? hold_ok : take;

  always_comb begin
    if (left) begin
      smp = take ? al_lo : (cfg.rep ? last_l : '0);
    end else if (!started) begin
      smp = '0;
    end else if (fresh_r) begin
      smp = per_frame ? hold_r : al_lo;
    end else begin
      smp = cfg.rep ? last_r : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      hold_ok <= 1'b0;
      hold_r  <= '0;
      last_l  <= '0;
      last_r  <= '0;
    end else if (!en) begin
      started <= 1'b0;
      hold_ok <= 1'b0;
      hold_r  <= '0;
      last_l  <= '0;
      last_r  <= '0;
    end else if (load) begin
      if (left) begin
        started <= 1'b1;
        hold_ok <= take;
        if (take) begin
          last_l <= al_lo;
          hold_r <= cfg.mono ? al_lo : al_hi;
        end
      end else if (started && fresh_r) begin
        last_r <= smp;
      end
    end
  end
endmodule

// File: rtl/aud_ser_shift.sv
module aud_ser_shift
  import aud_ser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              fall,
  input  logic              load,
  input  logic [WORD_W-1:0] smp,
  output logic              sdo
);
  logic [WORD_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      sdo <= 1'b0;
    end else if (!en) begin
      sh  <= '0;
      sdo <= 1'b0;
    end else if (fall) begin
      if (load) begin
        sdo <= smp[WORD_W-1];
        sh  <= {smp[WORD_W-2:0], 1'b0};
      end else begin
        sdo <= sh[WORD_W-1];
        sh  <= {sh[WORD_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
  import aud_ser_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [1:0]        cfg_format,
  input  logic [2:0]        cfg_wlen,
  input  logic              cfg_slot24,
  input  logic              cfg_mono,
  input  logic              cfg_repeat,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_data,
  input  logic              bck_in,
  input  logic              ws_in,
  output logic              sdo,
  output logic [SLOT_W-1:0] slot_bits
);
  cfg_t              cfg_q;
  logic              fall_evt;
  logic              ws_now;
  logic              slot_edge;
  logic              edge_prev;
  logic              load_evt;
  logic              is_left;
  logic [WORD_W-1:0] smp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (!enable) begin
      cfg_q.lj     <= (cfg_format == 2'd1);
      cfg_q.wlen   <= wlen_e'(cfg_wlen);
      cfg_q.slot24 <= cfg_slot24;
      cfg_q.mono   <= cfg_mono;
      cfg_q.rep    <= cfg_repeat;
    end
  end

  assign slot_bits = slot_len(cfg_q.wlen, cfg_q.slot24);

  aud_ser_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (enable),
    .bck_in    (bck_in),
    .ws_in     (ws_in),
    .fall      (fall_evt),
    .ws_now    (ws_now),
    .slot_edge (slot_edge),
    .edge_prev (edge_prev)
  );

  assign load_evt = fall_evt && (cfg_q.lj ? slot_edge : edge_prev);
  assign is_left  = cfg_q.lj ? ws_now : !ws_now;

  aud_ser_src u_src (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (enable),
    .cfg     (cfg_q),
    .load    (load_evt),
    .left    (is_left),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .s_data  (s_data),
    .smp     (smp)
  );

  aud_ser_shift u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (enable),
    .fall  (fall_evt),
    .load  (load_evt),
    .smp   (smp),
    .sdo   (sdo)
  );
endmodule

// File: rtl/aud_ser_tx_chk.sv
module aud_ser_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       fall_evt,
  input logic       load_evt,
  input logic       s_ready,
  input logic       sdo,
  input logic [5:0] slot_bits
);
  p_ready_on_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> load_evt);

  p_ready_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> !s_ready);

  p_quiet_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!sdo && !s_ready));

  p_sdo_on_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> $past(fall_evt || !enable));

  p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable)) |-> $stable(slot_bits));

  p_slot_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_bits == 6'd8) || (slot_bits == 6'd16) || (slot_bits == 6'd24) || (slot_bits == 6'd32));
endmodule

bind aud_ser_tx aud_ser_tx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .fall_evt  (fall_evt),
  .load_evt  (load_evt),
  .s_ready   (s_ready),
  .sdo       (sdo),
  .slot_bits (slot_bits)
);

// File: tb/aud_ser_tx_tb_top.sv
`timescale 1ns/1ps
module aud_ser_tx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  cfg_format = 2'd0;
  logic [2:0]  cfg_wlen = 3'd0;
  logic        cfg_slot24 = 1'b0;
  logic        cfg_mono = 1'b0;
  logic        cfg_repeat = 1'b0;
  logic        s_ready;
  logic        s_valid;
  logic [31:0] s_data;
  logic        bck = 1'b1;
  logic        ws = 1'b0;
  logic        sdo;
  logic [5:0]  slot_bits;

  logic [31:0] words [16];
  logic [31:0] exp_l [8];
  logic [31:0] exp_r [8];
  int n_words = 0;
  int idx = 0;
  int hs = 0;
  logic src_clr = 1'b0;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  assign s_valid = (idx < n_words);
  assign s_data  = (idx < 16) ? words[idx] : 32'h0;

  always @(posedge clk) begin
    if (src_clr) begin
      idx <= 0;
      hs  <= 0;
    end else if (s_valid && s_ready) begin
      idx <= idx + 1;
      hs  <= hs + 1;
    end
  end

  aud_ser_tx dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cfg_format(cfg_format), .cfg_wlen(cfg_wlen), .cfg_slot24(cfg_slot24),
    .cfg_mono(cfg_mono), .cfg_repeat(cfg_repeat),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .bck_in(bck), .ws_in(ws), .sdo(sdo), .slot_bits(slot_bits)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic setup(input logic [1:0] f, input logic [2:0] wl, input logic s24,
                       input logic mo, input logic rp, input int nw);
    @(negedge clk);
    enable = 1'b0;
    cfg_format = f; cfg_wlen = wl; cfg_slot24 = s24; cfg_mono = mo; cfg_repeat = rp;
    bck = 1'b1;
    ws = (f == 2'd1) ? 1'b0 : 1'b1;
    n_words = nw;
    src_clr = 1'b1;
    @(negedge clk);
    src_clr = 1'b0;
    repeat (4) @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
  endtask

  task automatic bit_period(input logic w, output logic b, output logic st);
    logic c;
    @(negedge clk);
    bck = 1'b0;
    ws = w;
    repeat (4) @(negedge clk);
    bck = 1'b1;
    b = sdo;
    repeat (3) @(negedge clk);
    c = sdo;
    st = (b == c);
  endtask

  task automatic run(input bit lj, input int sb, input int nf, input string req);
    logic lft, b, st, allst, expb;
    logic [31:0] a, prev, act, expv;
    lft = lj ? 1'b1 : 1'b0;
    prev = '0;
    allst = 1'b1;
    act = '0;
    for (int k = 0; k < 4; k++) begin
      bit_period(~lft, b, st);
      act = {act[30:0], b};
      allst &= st;
    end
    chk(act == 32'h0, "R10 lead-in quiet", act, 32'h0);
    for (int f = 0; f < nf; f++) begin
      for (int ch = 0; ch < 2; ch++) begin
        a = (ch == 1) ? exp_r[f] : exp_l[f];
        act = '0;
        expv = '0;
        for (int k = 0; k < sb; k++) begin
          bit_period((ch == 1) ? ~lft : lft, b, st);
          if (lj)          expb = a[31-k];
          else if (k == 0) expb = prev[32-sb];
          else             expb = a[32-k];
          act  = {act[30:0], b};
          expv = {expv[30:0], expb};
          allst &= st;
        end
        chk(act == expv, req, act, expv);
        prev = a;
      end
    end
    chk(allst, "R12 sdo held within bit period", {31'h0, allst}, 32'h1);
  endtask

  task automatic finish_off;
    @(negedge clk);
    enable = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(sdo == 1'b0, "R1 reset sdo", {31'h0, sdo}, 32'h0);
    chk(s_ready == 1'b0, "R1 reset ready", {31'h0, s_ready}, 32'h0);
    chk(slot_bits == 6'd32, "R6 reset slot", {26'h0, slot_bits}, 32'd32);
  endtask

  task automatic t_slot_bits;
    logic [5:0] e;
    for (int c = 0; c < 8; c++) begin
      for (int s = 0; s < 2; s++) begin
        @(negedge clk);
        cfg_wlen = c[2:0];
        cfg_slot24 = s[0];
        repeat (2) @(negedge clk);
        if (c == 0)      e = 6'd32;
        else if (c < 4)  e = s[0] ? 6'd24 : 6'd32;
        else if (c < 6)  e = 6'd16;
        else             e = 6'd8;
        chk(slot_bits == e, "R6 slot length (R1 capture while off)", {26'h0, slot_bits}, {26'h0, e});
      end
    end
  endtask

  task automatic t_lj24;
    words[0] = 32'hFFA5C3F1; words[1] = 32'h00123456;
    words[2] = 32'h77800001; words[3] = 32'h00FFFFFE;
    for (int f = 0; f < 2; f++) begin
      exp_l[f] = {words[2*f][23:0], 8'h00};
      exp_r[f] = {words[2*f+1][23:0], 8'h00};
    end
    setup(2'd1, 3'd1, 1'b0, 1'b0, 1'b0, 4);
    run(1'b1, 32, 2, "R2 R4 left-justified 24b");
    chk(hs == 4, "R9 word count stereo", hs, 4);
    finish_off();
    chk(sdo == 1'b0, "R1 disabled sdo", {31'h0, sdo}, 32'h0);
    chk(s_ready == 1'b0, "R1 disabled ready", {31'h0, s_ready}, 32'h0);
  endtask

  task automatic t_i2s32;
    words[0] = 32'h80000001; words[1] = 32'h7ABCDEF0;
    words[2] = 32'h12345679; words[3] = 32'hF0F00F0F;
    for (int f = 0; f < 2; f++) begin
      exp_l[f] = words[2*f];
      exp_r[f] = words[2*f+1];
    end
    setup(2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 4);
    run(1'b0, 32, 2, "R3 I2S 32b");
    chk(hs == 4, "R9 word count i2s", hs, 4);
    finish_off();
  endtask

  task automatic t_i2s18_fmt3;
    words[0] = 32'hFFF2AAAB; words[1] = 32'h00015555;
    for (int f = 0; f < 1; f++) begin
      exp_l[f] = {words[0][17:0], 14'h0};
      exp_r[f] = {words[1][17:0], 14'h0};
    end
    setup(2'd3, 3'd3, 1'b1, 1'b0, 1'b0, 2);
    chk(slot_bits == 6'd24, "R6 18b in 24 slot", {26'h0, slot_bits}, 32'd24);
    run(1'b0, 24, 1, "R3 R4 code3 as I2S 18b");
    finish_off();
  endtask

  task automatic t_pack16;
    words[0] = 32'hBEEF1234; words[1] = 32'h0F0FC3A5;
    for (int f = 0; f < 2; f++) begin
      exp_l[f] = {words[f][15:0], 16'h0};
      exp_r[f] = {words[f][31:16], 16'h0};
    end
    setup(2'd1, 3'd5, 1'b0, 1'b0, 1'b0, 2);
    run(1'b1, 16, 2, "R5 packed 16b");
    chk(hs == 2, "R9 R5 one word per frame", hs, 2);
    finish_off();
  endtask

  task automatic t_pack8;
    words[0] = 32'h77005AC3; words[1] = 32'h1234E781;
    for (int f = 0; f < 2; f++) begin
      exp_l[f] = {words[f][7:0], 24'h0};
      exp_r[f] = {words[f][15:8], 24'h0};
    end
    setup(2'd0, 3'd7, 1'b0, 1'b0, 1'b0, 2);
    run(1'b0, 8, 2, "R5 packed 8b");
    chk(hs == 2, "R9 packed 8b words", hs, 2);
    finish_off();
  endtask

  task automatic t_mono;
    words[0] = 32'hDEAD8001; words[1] = 32'h00007FFE;
    for (int f = 0; f < 2; f++) begin
      exp_l[f] = {words[f][15:0], 16'h0};
      exp_r[f] = exp_l[f];
    end
    setup(2'd0, 3'd4, 1'b0, 1'b1, 1'b0, 2);
    run(1'b0, 16, 2, "R7 mono duplicate");
    chk(hs == 2, "R7 mono words", hs, 2);
    finish_off();
  endtask

  task automatic t_underrun(input logic rp);
    words[0] = 32'h0000A001; words[1] = 32'h00005002;
    words[2] = 32'h0000C3C3;
    exp_l[0] = 32'hA0010000; exp_r[0] = 32'h50020000;
    exp_l[1] = 32'hC3C30000;
    exp_r[1] = rp ? exp_r[0] : 32'h0;
    exp_l[2] = rp ? exp_l[1] : 32'h0;
    exp_r[2] = rp ? exp_r[0] : 32'h0;
    setup(2'd1, 3'd4, 1'b0, 1'b0, rp, 3);
    run(1'b1, 16, 3, rp ? "R8 underrun repeat" : "R8 underrun zero");
    chk(hs == 3, "R8 words taken", hs, 3);
    finish_off();
  endtask

  task automatic t_cfg_lock;
    words[0] = 32'h00ABCDEF; words[1] = 32'h00654321;
    exp_l[0] = 32'hABCDEF00; exp_r[0] = 32'h65432100;
    setup(2'd1, 3'd1, 1'b1, 1'b0, 1'b0, 2);
    cfg_format = 2'd0; cfg_wlen = 3'd0; cfg_slot24 = 1'b0; cfg_mono = 1'b1;
    repeat (2) @(negedge clk);
    chk(slot_bits == 6'd24, "R11 slot held while on", {26'h0, slot_bits}, 32'd24);
    run(1'b1, 24, 1, "R11 stream keeps captured config");
    finish_off();
  endtask

  initial begin
    #750000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_slot_bits();
    t_lj24();
    t_i2s32();
    t_i2s18_fmt3();
    t_pack16();
    t_pack8();
    t_mono();
    t_underrun(1'b0);
    t_underrun(1'b1);
    t_cfg_lock();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule